// File: doc/BRIEF.md
# Time-Multiplexed Space Switch

This block carries 8-bit channel samples from a set of incoming highways to the same number of outgoing highways. It does this one time slot at a time. Each outgoing highway owns a connection memory with one word per slot of the frame. In every clock a slot counter selects the current word in all memories, and each word picks which incoming highway feeds that output during that slot. Because the crosspoints are set again in every slot, the switch holds no fixed crosspoint state. A sample keeps its slot position and only moves from one highway to another.

A host programs the connection memories one word at a time through a write port. Writes land in a shadow copy. The whole shadow is copied into the working copy on the clock edge that ends the last slot of a frame, so a frame never sees a partly updated map. A frame strobe marks slot 0 and realigns the counter. Without a strobe, the counter runs freely and wraps after the last slot. The output is registered, so each outlet sample appears one clock after the inlet sample it came from.

Top module: `tdm_space_switch`

## Requirements
- R1: While reset is held and after it is released, every outgoing highway carries the idle code 0xFF, and every connection word reads as disabled until the first frame boundary after a host write.
- R2: A cycle with `frame_sync` high is slot 0. Each later cycle is the next slot, whatever slot the counter held before the strobe.
- R3: If no strobe arrives, the cycle after slot NUM_SLOTS-1 (31 by default) is slot 0 again.
- R4: If the active word for output c in slot s is enabled, then output c during the cycle after slot s equals the sample that the selected inlet presented in slot s.
- R5: A host write to the shadow memory does not change any output before the clock edge that ends slot NUM_SLOTS-1. From the next slot 0 on, the new word is in force.
- R6: If the enable bit of the active word is clear, the output carries 0xFF for that slot, whatever the inlets present.
- R7: A host write made in the last slot of a frame still takes effect at the slot 0 that follows directly.
- R8: Several outputs may select the same inlet in the same slot, and each of them receives that sample.
- R9: A connection word is COL_W+1 bits wide. Bits [COL_W-1:0] (bits 1:0 by default) hold the inlet number, and bit COL_W (bit 2 by default) is the enable bit. Word 3'b110 selects inlet 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | High in the cycle that is slot 0 |
| hwy_in | input | NUM_HWY*8 | Inlet samples for the current slot; highway h occupies bits [8h+7:8h] |
| hwy_out | output | NUM_HWY*8 | Registered outlet samples; highway c occupies bits [8c+7:8c] |
| cfg_wr | input | 1 | Host write strobe for one connection word |
| cfg_col | input | COL_W | Outgoing highway whose memory is written |
| cfg_slot | input | SLOT_W | Slot address written; values at or above NUM_SLOTS are ignored |
| cfg_word | input | COL_W+1 | Connection word: enable bit above the inlet number |

## Verification
The bench covers the case where a host write and the frame-boundary copy fall in the same cycle. It steps the model to the last slot and writes a word for slot 0 in that very cycle. It then checks that the output in the next slot 0 already follows the new word rather than the old shadow contents. A second overlap is a frame strobe arriving mid-frame. The bench judges it by whether the counter restarts at slot 0 with no copy, so the old map stays in force until the next real wrap.

// File: rtl/tss_pkg.sv
// Package: shared constants and width helpers for the time-multiplexed space switch.
// Assumes: counts passed to idx_w are at least 1.
package tss_pkg;
    localparam int DEF_HWY    = 4;
    localparam int DEF_SLOTS  = 32;
    localparam int SAMPLE_BITS = 8;
    localparam logic [SAMPLE_BITS-1:0] DEF_IDLE = 8'hFF;

    // Index width for a count, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tss_slot_counter.sv
// Module: slot counter. Gives the slot number of the current cycle.
// A strobe forces slot 0; otherwise the count advances and wraps after the last slot.
// Assumes: NUM_SLOTS >= 2.
module tss_slot_counter #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              last_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] slot_q;

    // Current slot: strobe overrides the stored count.
    always_comb begin
        slot_o = frame_sync_i ? '0 : slot_q;
        last_o = (slot_o == LAST);
    end

    // Store the slot expected in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      slot_q <= '0;
        else if (last_o) slot_q <= '0;
        else             slot_q <= slot_o + SLOT_W'(1);
    end

    // R2: the cycle after a strobe is slot 1.
    assert_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync_i |=> (slot_q == SLOT_W'(1)));

    // R3: the cycle after the last slot without a strobe is slot 0.
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync_i && slot_q == LAST) |=> (slot_q == '0));

    // R3: the count never leaves the frame.
    assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= LAST);
endmodule

// File: rtl/tss_conn_mem.sv
// Module: connection memory for one outgoing highway.
// The host writes a shadow copy; the shadow is copied into the active copy
// on the edge that ends the last slot. A write in that cycle goes into the copy.
// Assumes: the read address is always below NUM_SLOTS.
module tss_conn_mem #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 5,
    parameter int COL_W     = 2,
    parameter int WORD_W    = 3,
    parameter int COL_IDX   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [COL_W-1:0]  wr_col_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [WORD_W-1:0] wr_word_i,
    input  logic              swap_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    output logic [WORD_W-1:0] rd_word_o
);
    logic [WORD_W-1:0] shadow_q [NUM_SLOTS];
    logic [WORD_W-1:0] active_q [NUM_SLOTS];
    logic [NUM_SLOTS*WORD_W-1:0] active_flat;
    logic hit;

    // Decode a host write aimed at this column and a valid slot.
    always_comb begin
        hit = wr_en_i && (wr_col_i == COL_W'(COL_IDX))
              && ({1'b0, wr_slot_i} < (SLOT_W+1)'(NUM_SLOTS));
    end

    // Shadow copy: host writes land here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) shadow_q[s] <= '0;
        end else if (hit) begin
            shadow_q[wr_slot_i] <= wr_word_i;
        end
    end

    // Active copy: refreshed from the shadow at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) active_q[s] <= '0;
        end else if (swap_i) begin
            for (int s = 0; s < NUM_SLOTS; s++)
                active_q[s] <= (hit && wr_slot_i == SLOT_W'(s)) ? wr_word_i : shadow_q[s];
        end
    end

    // Read the active word for the current slot.
    always_comb begin
        rd_word_o = active_q[rd_slot_i];
    end

    // Flatten the active copy for the stability check.
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++)
            active_flat[s*WORD_W +: WORD_W] = active_q[s];
    end

    // R5: the active map changes only on a frame-boundary edge.
    assert_hold_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> $stable(active_flat));

    // R7: a write in the boundary cycle is in force right after it.
    assert_late_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_i && hit && wr_slot_i == rd_slot_i) |=> (active_q[$past(wr_slot_i)] == $past(wr_word_i)));
endmodule

// File: rtl/tss_xpoint_col.sv
// Module: one crosspoint column with its output register.
// Closes at most one crosspoint per slot, chosen by the connection word;
// a clear enable bit or an out-of-range inlet gives the idle code.
// Assumes: the inlet field is the low COL_W bits, the enable bit just above.
module tss_xpoint_col #(
    parameter int NUM_HWY  = 4,
    parameter int SAMPLE_W = 8,
    parameter int COL_W    = 2,
    parameter logic [SAMPLE_W-1:0] IDLE = 8'hFF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_HWY*SAMPLE_W-1:0] in_bus_i,
    input  logic [COL_W:0]              word_i,
    output logic [SAMPLE_W-1:0]         out_o
);
    logic [COL_W-1:0]    sel;
    logic                closed;
    logic [SAMPLE_W-1:0] pick;

    // Split the word and select the inlet sample.
    always_comb begin
        sel    = word_i[COL_W-1:0];
        closed = word_i[COL_W] && ({1'b0, sel} < (COL_W+1)'(NUM_HWY));
        pick   = IDLE;
        for (int h = 0; h < NUM_HWY; h++)
            if (closed && sel == COL_W'(h)) pick = in_bus_i[h*SAMPLE_W +: SAMPLE_W];
    end

    // Register the outlet sample.
    always_ff @(posedge clk) begin
        if (!rst_n) out_o <= IDLE;
        else        out_o <= pick;
    end

    // R6: a disabled word yields the idle code one clock later.
    assert_idle_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !word_i[COL_W] |=> (out_o == IDLE));

    // R4: an enabled word passes the chosen inlet sample one clock later.
    assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_i[COL_W] && {1'b0, sel} < (COL_W+1)'(NUM_HWY))
        |=> (out_o == $past(in_bus_i[sel*SAMPLE_W +: SAMPLE_W])));
endmodule

// File: rtl/tdm_space_switch.sv
// Module: time-multiplexed space switch, top level.
// N inlets to N outlets per slot; one connection memory per outlet,
// addressed by the slot number; maps swap at the frame boundary.
// Assumes: NUM_HWY >= 2, NUM_SLOTS >= 2; samples keep their slot.
module tdm_space_switch
    import tss_pkg::*;
#(
    parameter int NUM_HWY   = DEF_HWY,
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int SAMPLE_W  = SAMPLE_BITS,
    parameter logic [SAMPLE_W-1:0] IDLE = DEF_IDLE,
    localparam int COL_W    = idx_w(NUM_HWY),
    localparam int SLOT_W   = idx_w(NUM_SLOTS),
    localparam int WORD_W   = COL_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_sync,
    input  logic [NUM_HWY*SAMPLE_W-1:0] hwy_in,
    output logic [NUM_HWY*SAMPLE_W-1:0] hwy_out,
    input  logic                        cfg_wr,
    input  logic [COL_W-1:0]            cfg_col,
    input  logic [SLOT_W-1:0]           cfg_slot,
    input  logic [WORD_W-1:0]           cfg_word
);
    logic [SLOT_W-1:0] slot;
    logic              last_slot;

    tss_slot_counter #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_sync_i (frame_sync),
        .slot_o       (slot),
        .last_o       (last_slot)
    );

    for (genvar c = 0; c < NUM_HWY; c++) begin : g_col
        logic [WORD_W-1:0] word;

        tss_conn_mem #(
            .NUM_SLOTS (NUM_SLOTS),
            .SLOT_W    (SLOT_W),
            .COL_W     (COL_W),
            .WORD_W    (WORD_W),
            .COL_IDX   (c)
        ) u_cm (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (cfg_wr),
            .wr_col_i  (cfg_col),
            .wr_slot_i (cfg_slot),
            .wr_word_i (cfg_word),
            .swap_i    (last_slot),
            .rd_slot_i (slot),
            .rd_word_o (word)
        );

        tss_xpoint_col #(
            .NUM_HWY  (NUM_HWY),
            .SAMPLE_W (SAMPLE_W),
            .COL_W    (COL_W),
            .IDLE     (IDLE)
        ) u_xp (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_bus_i (hwy_in),
            .word_i   (word),
            .out_o    (hwy_out[c*SAMPLE_W +: SAMPLE_W])
        );
    end

    // R1: the cycle after reset every outlet is idle.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (hwy_out == {NUM_HWY{IDLE}}));
endmodule

// File: tb/tdm_space_switch_tb.sv
// Bench: random and directed stimulus against a slot-accurate model.
module tdm_space_switch_tb;
    localparam int N = 4;
    localparam int S = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         frame_sync;
    logic [N*8-1:0] hwy_in;
    logic [N*8-1:0] hwy_out;
    logic         cfg_wr;
    logic [1:0]   cfg_col;
    logic [4:0]   cfg_slot;
    logic [2:0]   cfg_word;

    int checks = 0;
    int errors = 0;

    logic [2:0] m_sh  [N][S];
    logic [2:0] m_act [N][S];
    int         m_slot;

    always #5 clk = ~clk;

    tdm_space_switch u_dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .hwy_in(hwy_in), .hwy_out(hwy_out),
        .cfg_wr(cfg_wr), .cfg_col(cfg_col), .cfg_slot(cfg_slot), .cfg_word(cfg_word)
    );

    function automatic logic [7:0] expect_out(input logic [2:0] w, input logic [N*8-1:0] ins);
        return w[2] ? ins[w[1:0]*8 +: 8] : 8'hFF;
    endfunction

    task automatic check(input string tag, input int col, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s col %0d: actual %02h expected %02h", tag, col, act, exp);
        end
    endtask

    // One slot: drive at negedge, model the edge, check at next negedge.
    task automatic step(input logic fs, input logic wr, input int col, input int sl,
                        input logic [2:0] w, input string tag);
        logic [7:0] exp [N];
        int cur;
        frame_sync = fs; cfg_wr = wr; cfg_col = 2'(col); cfg_slot = 5'(sl); cfg_word = w;
        hwy_in = {$urandom, $urandom} [N*8-1:0];
        cur = fs ? 0 : m_slot;
        for (int c = 0; c < N; c++) exp[c] = expect_out(m_act[c][cur], hwy_in);
        @(posedge clk);
        if (wr) m_sh[col][sl] = w;
        if (cur == S-1) begin
            for (int c = 0; c < N; c++)
                for (int s = 0; s < S; s++) m_act[c][s] = m_sh[c][s];
            m_slot = 0;
        end else m_slot = cur + 1;
        @(negedge clk);
        for (int c = 0; c < N; c++) check(tag, c, hwy_out[c*8 +: 8], exp[c]);
    endtask

    task automatic idle_steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, 3'b000, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        for (int c = 0; c < N; c++)
            for (int s = 0; s < S; s++) begin m_sh[c][s] = '0; m_act[c][s] = '0; end
        m_slot = 0;
        rst_n = 1'b0; frame_sync = 1'b0; cfg_wr = 1'b0;
        cfg_col = '0; cfg_slot = '0; cfg_word = '0; hwy_in = '1 ^ 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < N; c++) check("R1 reset", c, hwy_out[c*8 +: 8], 8'hFF);
        rst_n = 1'b1;

        // R1: strobe, then idle until maps are written
        step(1'b1, 1'b0, 0, 0, 3'b000, "R2 strobe");
        idle_steps(5, "R1 idle after reset");

        // R5: program every word; nothing shows until the boundary
        for (int c = 0; c < N; c++)
            for (int s = 0; s < S; s++)
                step(1'b0, 1'b1, c, s, 3'($urandom_range(7)), "R5 staged write");

        // R4: run frames on the new map
        idle_steps(2*S, "R4 random inlets");

        // R3: free run across the wrap
        idle_steps(S + 8, "R3 wrap");

        // R2: strobe mid-frame realigns without swapping
        idle_steps(9, "R2 before strobe");
        step(1'b1, 1'b0, 0, 0, 3'b000, "R2 strobe mid-frame");
        idle_steps(S, "R2 after strobe");

        // R6: column 0 disabled in every slot
        for (int s = 0; s < S; s++) step(1'b0, 1'b1, 0, s, 3'b011, "R6 disable write");
        idle_steps(S + 4, "R6 disabled outlet");

        // R8, R9: word 3'b110 on every column selects inlet 2 everywhere
        for (int c = 0; c < N; c++)
            for (int s = 0; s < S; s++) step(1'b0, 1'b1, c, s, 3'b110, "R8 broadcast write");
        idle_steps(S + 2, "R8 R9 broadcast of inlet 2");

        // R7: write slot 0 of column 1 during the last slot
        while (m_slot != S-1) step(1'b0, 1'b0, 0, 0, 3'b000, "R7 align");
        step(1'b0, 1'b1, 1, 0, 3'b101, "R7 write in last slot");
        step(1'b0, 1'b0, 0, 0, 3'b000, "R7 slot 0 uses new word");
        idle_steps(4, "R7 after");

        // R4: mixed random traffic, writes and rare strobes
        for (int i = 0; i < 30*S; i++)
            step(($urandom_range(99) == 0), ($urandom_range(3) == 0),
                 $urandom_range(N-1), $urandom_range(S-1), 3'($urandom_range(7)), "R4 random mix");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule